// File: doc/BRIEF.md
# Dump trigger frame decoder

This block sits at a correlator input and watches a serial dump-control line, one bit per cycle in which `bit_vld` is high. The idle line carries an alternating 1/0 fill. A frame begins on the second of two consecutive zeros. The block then collects these fields in order, each sent MSB first:

- a 3-bit command
- an 8-bit count of selector pairs
- a 4-bit trigger tag
- an 8-bit station number
- the selector pairs, each a 5-bit baseband code followed by a 5-bit sub-band code
- a 16-bit phase-bin word
- a 4-bit check code

A single closing 0 bit follows the check code.

A frame is accepted when three conditions hold: its check code is correct, its closing bit is 0, and it is addressed to this station. An accepted frame is held as pending. A frame with a bad check code or a bad closing bit is discarded and counted. While the line is idle, two consecutive ones mark the dump instant. At the second of these ones, a pending frame is released as a one-cycle dump pulse that carries its command, tag, bank and phase bin. If the pending command is the synchronisation test, the dump instant is also compared with the timing strobe.

The station number, baseband index and sub-band index that this input answers to are strap inputs.

Top module: `dtf_decoder`

## Requirements
- R1: While reset is asserted, and after it is released, `dump_pulse` and `sync_fail` are 0 and `err_cnt` is 0.
- R2: In idle, a 0 bit that directly follows a 0 bit is the start bit. The fields after it are command(3), pair count(8), tag(4), station(8), count × {baseband(5), sub-band(5)}, phase bin(16), check code(4) and closing bit(1). Each field is sent MSB first, and only cycles with `bit_vld` high carry a bit.
- R3: The check code is the remainder of x^4+x+1 taken over every bit from the command through the phase bin, with the register starting at 0, and it is sent MSB first. A frame whose code is wrong is dropped, leaves any pending frame untouched, and increments `err_cnt`, which saturates at its maximum.
- R4: A frame whose closing bit is 1 is dropped and increments `err_cnt`.
- R5: A frame whose station field differs from `cfg_sid` is not accepted, unless R7 applies.
- R6: A pair selects this input when both of these hold:
  - its baseband code is 11111, or equals `00` followed by `cfg_bb`;
  - its sub-band code is 11111, or equals `cfg_sb`.

  A frame matches when any one of its pairs selects this input. A frame with zero pairs never matches.
- R7: Command 110 (reset recirculation counter) is accepted whatever its station and selector fields hold.
- R8: In idle, a 1 bit that directly follows a 1 bit is a dump instant. If a frame is pending, `dump_pulse` is high for exactly the one cycle after the clock edge that took that bit. During that cycle `dump_cmd`, `dump_tid` and `dump_bin` show the pending frame's fields, and the pending frame is then consumed.
- R9: A dump instant with no pending frame produces no pulse.
- R10: When several frames are accepted before one dump instant, only the most recently accepted frame is released, with a single pulse.
- R11: `dump_bank` equals bit 15 of the released phase bin.
- R12: When the released command is 111 (synchronisation test), `sync_fail` pulses together with `dump_pulse` if `t_strobe` was low on the dump-instant bit. It stays 0 if `t_strobe` was high on that bit, and it stays 0 for all other commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | Serial bit present this cycle |
| bit_in | input | 1 | Serial dump-control bit |
| t_strobe | input | 1 | Timing strobe, sampled with the dump-instant bit |
| cfg_sid | input | 8 | Station number of this input |
| cfg_bb | input | 3 | Baseband index of this input |
| cfg_sb | input | 5 | Sub-band index of this input |
| dump_pulse | output | 1 | One-cycle dump pulse |
| dump_cmd | output | 3 | Released command |
| dump_tid | output | 4 | Released trigger tag |
| dump_bank | output | 1 | Released bank (phase-bin MSB) |
| dump_bin | output | 16 | Released phase-bin word |
| sync_fail | output | 1 | Synchronisation-test misalignment, pulses with dump_pulse |
| err_cnt | output | 8 | Saturating count of dropped frames |

## Verification
The dump pulse and the synchronisation judgement fall in the same cycle, because `sync_fail` is decided from `t_strobe` on the very bit that releases the pulse. The bench sends two synchronisation-test frames. For the first, the strobe is raised on the second trigger one. For the second, the strobe is raised one bit early. The scoreboard compares `sync_fail` against the expected flag in the same sample as the pulse fields. A second overlap is a dropped frame arriving while an earlier frame is still pending. The bench sends a good frame, then a corrupted one, then a trigger, and expects the good frame to be released while the error count steps by one.

// File: rtl/dtf_pkg.sv
package dtf_pkg;
  localparam int CMD_W  = 3;
  localparam int LEN_W  = 8;
  localparam int TID_W  = 4;
  localparam int SID_W  = 8;
  localparam int BBI_W  = 3;
  localparam int SEL_W  = 5;
  localparam int BIN_W  = 16;
  localparam int CRC_W  = 4;
  localparam int CNT_W  = $clog2(BIN_W);

  typedef enum logic [CMD_W-1:0] {
    CMD_FIRST      = 3'b000,
    CMD_ADD        = 3'b001,
    CMD_LAST       = 3'b010,
    CMD_SPEED      = 3'b011,
    CMD_DISCARD    = 3'b100,
    CMD_SINGLE     = 3'b101,
    CMD_RECIRC_RST = 3'b110,
    CMD_SYNC_TEST  = 3'b111
  } dump_cmd_e;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_LEN, S_TID, S_SID, S_BB, S_SB, S_BIN, S_CRC, S_TRAIL
  } pstate_e;
endpackage

// File: rtl/dtf_crc4.sv
module dtf_crc4 #(
  parameter int          W    = 4,
  parameter logic [W-1:0] POLY = 4'b0011
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         d,
  output logic [W-1:0] rem
);
  logic [W-1:0] rem_d;
  logic         fb;

  always_comb begin
    fb    = rem[W-1] ^ d;
    rem_d = rem;
    if (clr)     rem_d = '0;
    else if (en) rem_d = {rem[W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem <= '0;
    else        rem <= rem_d;
  end
endmodule

// File: rtl/dtf_sel_match.sv
module dtf_sel_match import dtf_pkg::*; (
  input  logic [SEL_W-1:0] bb,
  input  logic [SEL_W-1:0] sb,
  input  logic [BBI_W-1:0] cfg_bb,
  input  logic [SEL_W-1:0] cfg_sb,
  output logic             hit
);
  localparam logic [SEL_W-1:0] ALL = '1;
  logic bb_hit, sb_hit;

  always_comb begin
    bb_hit = (bb == ALL) || (bb == {{(SEL_W-BBI_W){1'b0}}, cfg_bb});
    sb_hit = (sb == ALL) || (sb == cfg_sb);
    hit    = bb_hit && sb_hit;
  end
endmodule

// File: rtl/dtf_parser.sv
module dtf_parser import dtf_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_vld,
  input  logic             bit_in,
  input  logic [SID_W-1:0] cfg_sid,
  input  logic [BBI_W-1:0] cfg_bb,
  input  logic [SEL_W-1:0] cfg_sb,
  output logic             frame_acc,
  output logic             frame_err,
  output logic             trig_now,
  output logic [CMD_W-1:0] fr_cmd,
  output logic [TID_W-1:0] fr_tid,
  output logic [BIN_W-1:0] fr_bin
);
  pstate_e          state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BIN_W-1:0] sh_q, sh_d, sh_nx;
  logic             prev_q, prev_d, pok_q, pok_d;
  logic [CMD_W-1:0] cmd_q, cmd_d;
  logic [LEN_W-1:0] len_q, len_d, left_q, left_d;
  logic [TID_W-1:0] tid_q, tid_d;
  logic [SEL_W-1:0] bb_q, bb_d;
  logic [BIN_W-1:0] bin_q, bin_d;
  logic             sid_hit_q, sid_hit_d, any_q, any_d;
  logic             crc_clr, crc_en, pair_hit, last;
  logic [CRC_W-1:0] crc_rem;

  dtf_crc4 #(.W(CRC_W)) u_crc (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en), .d(bit_in), .rem(crc_rem)
  );

  dtf_sel_match u_match (
    .bb(bb_q), .sb(sh_nx[SEL_W-1:0]), .cfg_bb(cfg_bb), .cfg_sb(cfg_sb), .hit(pair_hit)
  );

  assign sh_nx = {sh_q[BIN_W-2:0], bit_in};
  assign last  = (cnt_q == '0);

  always_comb begin
    state_d = state_q; cnt_d = cnt_q; sh_d = sh_q;
    prev_d = prev_q; pok_d = pok_q; cmd_d = cmd_q; len_d = len_q;
    left_d = left_q; tid_d = tid_q; bb_d = bb_q; bin_d = bin_q;
    sid_hit_d = sid_hit_q; any_d = any_q;
    frame_acc = 1'b0; frame_err = 1'b0; trig_now = 1'b0;
    crc_clr = 1'b0; crc_en = 1'b0;
    if (bit_vld) begin
      sh_d  = sh_nx;
      cnt_d = cnt_q - 1'b1;
      case (state_q)
        S_IDLE: begin
          if (pok_q && !prev_q && !bit_in) begin
            state_d = S_CMD; cnt_d = CNT_W'(CMD_W-1); crc_clr = 1'b1; pok_d = 1'b0;
          end else if (pok_q && prev_q && bit_in) begin
            trig_now = 1'b1; pok_d = 1'b0;
          end else begin
            prev_d = bit_in; pok_d = 1'b1;
          end
        end
        S_CMD: begin
          crc_en = 1'b1;
          if (last) begin cmd_d = sh_nx[CMD_W-1:0]; state_d = S_LEN; cnt_d = CNT_W'(LEN_W-1); end
        end
        S_LEN: begin
          crc_en = 1'b1;
          if (last) begin len_d = sh_nx[LEN_W-1:0]; state_d = S_TID; cnt_d = CNT_W'(TID_W-1); end
        end
        S_TID: begin
          crc_en = 1'b1;
          if (last) begin tid_d = sh_nx[TID_W-1:0]; state_d = S_SID; cnt_d = CNT_W'(SID_W-1); end
        end
        S_SID: begin
          crc_en = 1'b1;
          if (last) begin
            sid_hit_d = (sh_nx[SID_W-1:0] == cfg_sid);
            any_d     = 1'b0;
            left_d    = len_q;
            if (len_q == '0) begin state_d = S_BIN; cnt_d = CNT_W'(BIN_W-1); end
            else             begin state_d = S_BB;  cnt_d = CNT_W'(SEL_W-1); end
          end
        end
        S_BB: begin
          crc_en = 1'b1;
          if (last) begin bb_d = sh_nx[SEL_W-1:0]; state_d = S_SB; cnt_d = CNT_W'(SEL_W-1); end
        end
        S_SB: begin
          crc_en = 1'b1;
          if (last) begin
            if (pair_hit) any_d = 1'b1;
            left_d = left_q - 1'b1;
            if (left_q == LEN_W'(1)) begin state_d = S_BIN; cnt_d = CNT_W'(BIN_W-1); end
            else                     begin state_d = S_BB;  cnt_d = CNT_W'(SEL_W-1); end
          end
        end
        S_BIN: begin
          crc_en = 1'b1;
          if (last) begin bin_d = sh_nx; state_d = S_CRC; cnt_d = CNT_W'(CRC_W-1); end
        end
        S_CRC: begin
          crc_en = 1'b1;
          if (last) state_d = S_TRAIL;
        end
        S_TRAIL: begin
          if ((crc_rem == '0) && !bit_in)
            frame_acc = (cmd_q == CMD_RECIRC_RST) || (sid_hit_q && any_q);
          else
            frame_err = 1'b1;
          state_d = S_IDLE; prev_d = bit_in; pok_d = 1'b1;
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE; cnt_q <= '0; sh_q <= '0; prev_q <= 1'b0; pok_q <= 1'b0;
      cmd_q <= '0; len_q <= '0; left_q <= '0; tid_q <= '0; bb_q <= '0; bin_q <= '0;
      sid_hit_q <= 1'b0; any_q <= 1'b0;
    end else begin
      state_q <= state_d; cnt_q <= cnt_d; sh_q <= sh_d; prev_q <= prev_d; pok_q <= pok_d;
      cmd_q <= cmd_d; len_q <= len_d; left_q <= left_d; tid_q <= tid_d; bb_q <= bb_d;
      bin_q <= bin_d; sid_hit_q <= sid_hit_d; any_q <= any_d;
    end
  end

  assign fr_cmd = cmd_q;
  assign fr_tid = tid_q;
  assign fr_bin = bin_q;
endmodule

// File: rtl/dtf_decoder.sv
module dtf_decoder import dtf_pkg::*; #(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_vld,
  input  logic             bit_in,
  input  logic             t_strobe,
  input  logic [SID_W-1:0] cfg_sid,
  input  logic [BBI_W-1:0] cfg_bb,
  input  logic [SEL_W-1:0] cfg_sb,
  output logic             dump_pulse,
  output logic [CMD_W-1:0] dump_cmd,
  output logic [TID_W-1:0] dump_tid,
  output logic             dump_bank,
  output logic [BIN_W-1:0] dump_bin,
  output logic             sync_fail,
  output logic [ERR_W-1:0] err_cnt
);
  logic             rst_meta, rst_sync_n;
  logic             frame_acc, frame_err, trig_now;
  logic [CMD_W-1:0] fr_cmd, pcmd_q, pcmd_d, ocmd_d;
  logic [TID_W-1:0] fr_tid, ptid_q, ptid_d, otid_d;
  logic [BIN_W-1:0] fr_bin, pbin_q, pbin_d, obin_d;
  logic             pend_q, pend_d, pulse_d, sfail_d;
  logic [ERR_W-1:0] err_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin rst_meta <= 1'b0; rst_sync_n <= 1'b0; end
    else        begin rst_meta <= 1'b1; rst_sync_n <= rst_meta; end
  end

  dtf_parser u_parser (
    .clk(clk), .rst_n(rst_sync_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .cfg_sid(cfg_sid), .cfg_bb(cfg_bb), .cfg_sb(cfg_sb),
    .frame_acc(frame_acc), .frame_err(frame_err), .trig_now(trig_now),
    .fr_cmd(fr_cmd), .fr_tid(fr_tid), .fr_bin(fr_bin)
  );

  always_comb begin
    pend_d = pend_q; pcmd_d = pcmd_q; ptid_d = ptid_q; pbin_d = pbin_q;
    ocmd_d = dump_cmd; otid_d = dump_tid; obin_d = dump_bin;
    pulse_d = 1'b0; sfail_d = 1'b0; err_d = err_cnt;
    if (frame_acc) begin
      pend_d = 1'b1; pcmd_d = fr_cmd; ptid_d = fr_tid; pbin_d = fr_bin;
    end
    if (trig_now) begin
      pend_d = 1'b0;
      if (pend_q) begin
        pulse_d = 1'b1; ocmd_d = pcmd_q; otid_d = ptid_q; obin_d = pbin_q;
        sfail_d = (pcmd_q == CMD_SYNC_TEST) && !t_strobe;
      end
    end
    if (frame_err && !(&err_cnt)) err_d = err_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pend_q <= 1'b0; pcmd_q <= '0; ptid_q <= '0; pbin_q <= '0;
      dump_pulse <= 1'b0; dump_cmd <= '0; dump_tid <= '0; dump_bin <= '0;
      sync_fail <= 1'b0; err_cnt <= '0;
    end else begin
      pend_q <= pend_d; pcmd_q <= pcmd_d; ptid_q <= ptid_d; pbin_q <= pbin_d;
      dump_pulse <= pulse_d; dump_cmd <= ocmd_d; dump_tid <= otid_d; dump_bin <= obin_d;
      sync_fail <= sfail_d; err_cnt <= err_d;
    end
  end

  assign dump_bank = dump_bin[BIN_W-1];
endmodule

// File: rtl/dtf_decoder_chk.sv
module dtf_decoder_chk #(
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dump_pulse,
  input logic             sync_fail,
  input logic [2:0]       dump_cmd,
  input logic [ERR_W-1:0] err_cnt,
  input logic             pend
);
  // R1
  always @(posedge clk)
    if (!rst_n) reset_quiet_chk: assert (!dump_pulse && !sync_fail && err_cnt == '0);

  // R8
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dump_pulse |=> !dump_pulse);

  // R9
  pulse_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dump_pulse |-> ($past(pend) && !pend));

  // R12
  sync_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_fail |-> (dump_pulse && dump_cmd == 3'b111));

  // R3
  err_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt != $past(err_cnt)) |-> (err_cnt == $past(err_cnt) + 1'b1));
endmodule

bind dtf_decoder dtf_decoder_chk #(.ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .dump_pulse(dump_pulse), .sync_fail(sync_fail),
  .dump_cmd(dump_cmd), .err_cnt(err_cnt), .pend(pend_q)
);

// File: tb/dtf_decoder_tb.sv
module dtf_decoder_tb;
  localparam logic [7:0] CFG_SID = 8'h23;
  localparam logic [2:0] CFG_BB  = 3'd5;
  localparam logic [4:0] CFG_SB  = 5'd16;

  logic clk = 1'b0, rst_n = 1'b0, bit_vld = 1'b0, bit_in = 1'b0, t_strobe = 1'b0;
  logic dump_pulse, dump_bank, sync_fail;
  logic [2:0] dump_cmd;
  logic [3:0] dump_tid;
  logic [15:0] dump_bin;
  logic [7:0] err_cnt;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  typedef struct { logic [2:0] cmd; logic [3:0] tid; logic [15:0] bin; logic sync; } item_t;
  item_t exp_q[$];
  logic  fq[$];

  bit m_pend = 1'b0;
  logic [2:0] m_cmd; logic [3:0] m_tid; logic [15:0] m_bin;

  always #10 clk = ~clk;

  dtf_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in), .t_strobe(t_strobe),
    .cfg_sid(CFG_SID), .cfg_bb(CFG_BB), .cfg_sb(CFG_SB),
    .dump_pulse(dump_pulse), .dump_cmd(dump_cmd), .dump_tid(dump_tid),
    .dump_bank(dump_bank), .dump_bin(dump_bin), .sync_fail(sync_fail), .err_cnt(err_cnt)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  task automatic drive_bit(input logic b, input logic t);
    @(negedge clk); bit_in = b; bit_vld = 1'b1; t_strobe = t;
    @(negedge clk); bit_vld = 1'b0; bit_in = ~b; t_strobe = 1'b0;
  endtask

  task automatic push_field(input logic [15:0] v, input int w);
    for (int i = w - 1; i >= 0; i--) fq.push_back(v[i]);
  endtask

  function automatic bit sel_ok(input logic [4:0] bb, input logic [4:0] sb);
    return ((bb == 5'h1f) || (bb == {2'b00, CFG_BB})) && ((sb == 5'h1f) || (sb == CFG_SB));
  endfunction

  // R2 R3 R4 R5 R6 R7 R10: framing and acceptance model
  task automatic send_frame(input logic [2:0] c, input logic [3:0] tid, input logic [7:0] sid,
                            input int np, input logic [4:0] b0, input logic [4:0] s0,
                            input logic [4:0] b1, input logic [4:0] s1, input logic [15:0] bin,
                            input bit bad_crc, input bit bad_trail);
    logic [3:0] crc;
    bit sel;
    fq.delete();
    push_field(16'(c), 3); push_field(16'(np), 8); push_field(16'(tid), 4);
    push_field(16'(sid), 8);
    if (np >= 1) begin push_field(16'(b0), 5); push_field(16'(s0), 5); end
    if (np >= 2) begin push_field(16'(b1), 5); push_field(16'(s1), 5); end
    push_field(bin, 16);
    crc = 4'h0;
    foreach (fq[i]) begin
      logic fbk;
      fbk = crc[3] ^ fq[i];
      crc = {crc[2:0], 1'b0} ^ (fbk ? 4'b0011 : 4'b0000);
    end
    if (bad_crc) crc = crc ^ 4'b0001;
    push_field(16'(crc), 4);
    drive_bit(1'b1, 1'b0); drive_bit(1'b0, 1'b0); drive_bit(1'b1, 1'b0); drive_bit(1'b0, 1'b0);
    drive_bit(1'b0, 1'b0);
    foreach (fq[i]) drive_bit(fq[i], 1'b0);
    drive_bit(bad_trail, 1'b0);
    sel = (np >= 1 && sel_ok(b0, s0)) || (np >= 2 && sel_ok(b1, s1));
    if (!bad_crc && !bad_trail && (c == 3'b110 || (sid == CFG_SID && sel))) begin
      m_pend = 1'b1; m_cmd = c; m_tid = tid; m_bin = bin;
    end
  endtask

  // R8 R9 R12: dump instant
  task automatic send_trig(input bit t_on_second, input string req);
    bit expect_pulse;
    expect_pulse = m_pend;
    if (m_pend) exp_q.push_back('{m_cmd, m_tid, m_bin, (m_cmd == 3'b111) && !t_on_second});
    m_pend = 1'b0;
    drive_bit(1'b1, !t_on_second);
    drive_bit(1'b1, t_on_second);
    check(dump_pulse == expect_pulse, req, "dump_pulse after trigger", 32'(dump_pulse),
          32'(expect_pulse));
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && dump_pulse) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9", "unexpected dump_pulse", 32'd1, 32'd0);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          check(dump_cmd == it.cmd && dump_tid == it.tid && dump_bin == it.bin, "R8",
                "cmd/tid/bin", {9'd0, dump_cmd, dump_tid, dump_bin},
                {9'd0, it.cmd, it.tid, it.bin});
          check(dump_bank == it.bin[15], "R11", "bank", 32'(dump_bank), 32'(it.bin[15]));
          check(sync_fail == it.sync, "R12", "sync_fail", 32'(sync_fail), 32'(it.sync));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 during reset
    check(dump_pulse == 1'b0, "R1", "pulse in reset", 32'(dump_pulse), 0);
    check(err_cnt == 8'd0, "R1", "err_cnt in reset", 32'(err_cnt), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!dump_pulse && !sync_fail && err_cnt == 0, "R1", "after release",
          {23'd0, dump_pulse, sync_fail, err_cnt}, 0);

    // R2 R5 R6 R11: wildcards, bank set
    send_frame(3'b000, 4'd3, CFG_SID, 1, 5'h1f, 5'h1f, 5'h0, 5'h0, 16'h8003, 0, 0);
    send_trig(1'b0, "R2");
    // R9: nothing pending
    send_trig(1'b0, "R9");
    // R6: explicit selectors
    send_frame(3'b001, 4'd9, CFG_SID, 1, 5'd5, 5'd16, 5'h0, 5'h0, 16'h0042, 0, 0);
    send_trig(1'b0, "R6");
    // R5: foreign station
    send_frame(3'b010, 4'd2, 8'h24, 1, 5'h1f, 5'h1f, 5'h0, 5'h0, 16'h0011, 0, 0);
    send_trig(1'b0, "R5");
    // R6: second pair matches
    send_frame(3'b101, 4'd7, CFG_SID, 2, 5'd6, 5'h1f, 5'h1f, 5'd16, 16'h1234, 0, 0);
    send_trig(1'b0, "R6");
    // R6: no pair matches (01101 is not 00+101)
    send_frame(3'b011, 4'd1, CFG_SID, 2, 5'd5, 5'd17, 5'd13, 5'd16, 16'h0077, 0, 0);
    send_trig(1'b0, "R6");
    // R7: recirculation reset ignores selection
    send_frame(3'b110, 4'd5, 8'h99, 1, 5'd0, 5'd0, 5'h0, 5'h0, 16'h0000, 0, 0);
    send_trig(1'b0, "R7");
    // R3: bad check code dropped, earlier frame kept
    send_frame(3'b000, 4'd1, CFG_SID, 1, 5'h1f, 5'h1f, 5'h0, 5'h0, 16'h0007, 0, 0);
    send_frame(3'b100, 4'd2, CFG_SID, 1, 5'h1f, 5'h1f, 5'h0, 5'h0, 16'h0009, 1, 0);
    check(err_cnt == 8'd1, "R3", "err_cnt after bad code", 32'(err_cnt), 1);
    send_trig(1'b0, "R3");
    // R10: latest frame wins, one pulse
    send_frame(3'b100, 4'd4, CFG_SID, 1, 5'h1f, 5'h1f, 5'h0, 5'h0, 16'h0005, 0, 0);
    send_frame(3'b001, 4'd6, CFG_SID, 1, 5'h1f, 5'd16, 5'h0, 5'h0, 16'h8100, 0, 0);
    send_trig(1'b0, "R10");
    send_trig(1'b0, "R10");
    // R4: closing bit 1
    send_frame(3'b000, 4'd8, CFG_SID, 1, 5'h1f, 5'h1f, 5'h0, 5'h0, 16'h0001, 0, 1);
    check(err_cnt == 8'd2, "R4", "err_cnt after bad closing bit", 32'(err_cnt), 2);
    drive_bit(1'b0, 1'b0);
    send_trig(1'b0, "R4");
    // R12: synchronisation test aligned, then misaligned
    send_frame(3'b111, 4'd10, CFG_SID, 1, 5'h1f, 5'h1f, 5'h0, 5'h0, 16'h0020, 0, 0);
    send_trig(1'b1, "R12");
    send_frame(3'b111, 4'd11, CFG_SID, 1, 5'h1f, 5'h1f, 5'h0, 5'h0, 16'h0021, 0, 0);
    send_trig(1'b0, "R12");
    // R6: zero pairs never match
    send_frame(3'b000, 4'd12, CFG_SID, 0, 5'h0, 5'h0, 5'h0, 5'h0, 16'h0030, 0, 0);
    send_trig(1'b0, "R6");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R8", "scoreboard drained", 32'(exp_q.size()), 0);
    check(err_cnt == 8'd2, "R3", "final err_cnt", 32'(err_cnt), 2);
    finish_run();
  end
endmodule